// File: doc/BRIEF.md
# Request Stream Sideband Generator

This block is the sending end of a stream that hands received requests to user logic. It accepts one request at a time: a four-Dword descriptor with its decoded fields, and then the request's payload, one Dword per transfer. It packs the descriptor and the payload into AXI4-Stream beats of 64, 128 or 256 bits, chosen at elaboration. On every beat it drives a matching 85-bit sideband word. The payload follows the descriptor directly, with no gap (Dword-aligned packing).

The sideband word carries five things. It carries the effective first and last byte enables and a per-byte mask that marks the valid payload bytes. It carries a start-of-packet flag and the processing-hint fields. It also carries one odd-parity bit per data byte. The block derives the payload mask itself from the length and the byte enables. It also applies the special rules for atomic requests, messages with data, one-Dword requests and zero-length requests. Downstream logic can use the sideband bits directly and does not have to recompute them.

Top module: `request_sideband_gen`

## Requirements
- R1: Packet Dword d goes to beat d/N, lane d%N, where N = DATA_W/32. Dwords 0..3 are the descriptor, lowest Dword first, and payload Dword k is packet Dword 4+k. The payload length is req_len Dwords for type codes 1 (memory write), 3 (I/O write), 4 (atomic) and 6 (message with data). It is zero for codes 0 (memory read), 2 (I/O read) and 5 (message without data).
- R2: m_tkeep bit j is 1 when lane j holds a packet Dword. Every beat except the last has all N low bits set, so the bits are contiguous from bit 0. Bits at or above N are 0.
- R3: m_tlast is 1 on the final beat of a packet only, which is also the first beat when the packet fits in one beat. Sideband bit [40] (start of packet) is 1 on the first beat only.
- R4: While m_tvalid is 1 and m_tready is 0, m_tvalid stays 1 and m_tdata, m_tkeep, m_tlast and m_tuser hold their values on the next cycle.
- R5: On the first beat, sideband bits [3:0] carry the effective first enables and bits [7:4] the effective last enables. On later beats both fields are 0. For type codes 4 and 6, both enables are forced to 4'hF.
- R6: For types other than 4 and 6, the effective last enables are 4'h0 when req_len is 1. Otherwise they are req_last_be. The effective first enables are always req_first_be.
- R7: Sideband bits [39:8] (bit 8+i for byte i) are 0 for descriptor bytes, empty lanes and bytes above the bus width. For payload Dword k of P Dwords, the lane's four bits are: the first enables when k = 0; the last enables when k = P-1 > 0; 4'hF otherwise.
- R8: A memory write with req_len = 1 and req_first_be = 0 (zero-length write) transfers its single payload Dword with all of bits [39:8] equal to 0.
- R9: On the first beat, bit [42] carries the hint-present flag, bits [44:43] the hint type and bits [52:45] the steering tag. All three fields are 0 on later beats.
- R10: For byte i inside the bus width, bit [53+i] is the odd parity of m_tdata byte i, so byte and bit together hold an odd number of ones. Parity bits above the width are 0, and bit [41] is always 0.
- R11: After reset m_tvalid is 0 and req_ready is 1. req_ready is 0 from the cycle after a request is accepted until its last beat has been taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request descriptor present |
| req_ready | output | 1 | Block idle, accepts a request |
| req_type | input | 3 | Request type code (see R1) |
| req_len | input | LEN_W (11) | Length in Dwords, 1 or more |
| req_first_be | input | 4 | First-Dword byte enables |
| req_last_be | input | 4 | Last-Dword byte enables |
| req_hint_present | input | 1 | Processing hint present |
| req_hint_type | input | 2 | Hint type |
| req_steer_tag | input | 8 | Steering tag |
| req_desc | input | 128 | Descriptor, Dword 0 in bits [31:0] |
| pl_valid | input | 1 | Payload Dword present |
| pl_ready | output | 1 | Payload Dword taken this cycle |
| pl_data | input | 32 | Payload Dword |
| m_tvalid | output | 1 | Output beat valid |
| m_tready | input | 1 | Downstream accepts beat |
| m_tdata | output | 256 | Beat data, upper bits 0 below 256 |
| m_tkeep | output | 8 | Per-Dword valid |
| m_tlast | output | 1 | Final beat of packet |
| m_tuser | output | 85 | Sideband word |

## Verification
The hardest situation to reach is a final beat whose last lanes are empty. It must also carry the last enables in the right lane while the downstream side stalls and the payload source pauses, because the length, the bus width and both handshakes must all line up at once. The stimulus gets there in three ways. Directed lengths place the last payload Dword in every lane position at 128 bits. Payload pauses are random, and ready stalls are random at a 60 % acceptance rate. Random requests then cover all seven types with lengths up to 20. A separate directed set covers zero-length writes, one-Dword requests, and two-Dword writes with non-contiguous enables, where the first and last enables fall in neighbouring lanes.

// File: rtl/rsg_pkg.sv
package rsg_pkg;
   localparam int MAX_DATA_W = 256;
   localparam int MAX_KEEP_W = 8;
   localparam int TUSER_W    = 85;
   localparam int DESC_DW    = 4;
   // sideband field positions, fixed by the downstream decoder
   localparam int U_FBE   = 0;
   localparam int U_LBE   = 4;
   localparam int U_PBE   = 8;
   localparam int U_SOP   = 40;
   localparam int U_DISC  = 41;
   localparam int U_HINT  = 42;
   localparam int U_HTYPE = 43;
   localparam int U_TAG   = 45;
   localparam int U_PAR   = 53;

   typedef enum logic [2:0] {
      RK_MEM_RD   = 3'd0,
      RK_MEM_WR   = 3'd1,
      RK_IO_RD    = 3'd2,
      RK_IO_WR    = 3'd3,
      RK_ATOMIC   = 3'd4,
      RK_MSG      = 3'd5,
      RK_MSG_DATA = 3'd6
   } req_kind_t;

   typedef enum logic [1:0] {S_IDLE, S_FILL, S_SEND} gen_state_t;
endpackage

// File: rtl/rsg_be_rules.sv
module rsg_be_rules
   import rsg_pkg::*;
#(
   parameter int LEN_W = 11
) (
   input  logic [2:0]       kind,
   input  logic [LEN_W-1:0] len,
   input  logic [3:0]       fe_in,
   input  logic [3:0]       le_in,
   output logic [3:0]       fe_eff,
   output logic [3:0]       le_eff,
   output logic [LEN_W-1:0] pay_cnt
);
   logic forced;
   logic has_pay;

   always_comb begin
      forced  = 1'b0;
      has_pay = 1'b0;
      unique case (req_kind_t'(kind))
         RK_MEM_WR, RK_IO_WR: has_pay = 1'b1;
         RK_ATOMIC, RK_MSG_DATA: begin
            has_pay = 1'b1;
            forced  = 1'b1;
         end
         default: ;
      endcase
      fe_eff  = forced ? 4'hF : fe_in;
      le_eff  = forced ? 4'hF : ((len <= LEN_W'(1)) ? 4'h0 : le_in);
      pay_cnt = has_pay ? len : '0;
   end
endmodule

// File: rtl/rsg_lane_be.sv
module rsg_lane_be #(
   parameter int LEN_W = 11
) (
   input  logic [LEN_W-1:0] pay_idx,
   input  logic [LEN_W-1:0] pay_cnt,
   input  logic [3:0]       fe,
   input  logic [3:0]       le,
   output logic [3:0]       be
);
   always_comb begin
      if (pay_idx == '0)                        be = fe;
      else if (pay_idx == pay_cnt - LEN_W'(1))  be = le;
      else                                      be = 4'hF;
   end
endmodule

// File: rtl/rsg_parity.sv
module rsg_parity #(
   parameter int DATA_W = 256
) (
   input  logic [DATA_W-1:0] data,
   output logic [31:0]       par
);
   localparam int NB = DATA_W / 8;

   for (genvar i = 0; i < 32; i++) begin : g_byte
      if (i < NB) begin : g_used
         assign par[i] = ~^data[8*i +: 8];
      end else begin : g_tied
         assign par[i] = 1'b0;
      end
   end
endmodule

// File: rtl/request_sideband_gen.sv
module request_sideband_gen
   import rsg_pkg::*;
#(
   parameter int DATA_W = 256,
   parameter int LEN_W  = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [2:0]        req_type,
   input  logic [LEN_W-1:0]  req_len,
   input  logic [3:0]        req_first_be,
   input  logic [3:0]        req_last_be,
   input  logic              req_hint_present,
   input  logic [1:0]        req_hint_type,
   input  logic [7:0]        req_steer_tag,
   input  logic [127:0]      req_desc,
   input  logic              pl_valid,
   output logic              pl_ready,
   input  logic [31:0]       pl_data,
   output logic              m_tvalid,
   input  logic              m_tready,
   output logic [255:0]      m_tdata,
   output logic [7:0]        m_tkeep,
   output logic              m_tlast,
   output logic [84:0]       m_tuser
);
   localparam int NDW    = DATA_W / 32;
   localparam int NB     = DATA_W / 8;
   localparam int SLOT_W = $clog2(NDW);
   localparam int CNT_W  = LEN_W + 1;

   if (!(DATA_W == 64 || DATA_W == 128 || DATA_W == 256)) begin : g_bad_width
      $error("request_sideband_gen: DATA_W must be 64, 128 or 256");
   end
   if (LEN_W < 2) begin : g_bad_len
      $error("request_sideband_gen: LEN_W must be at least 2");
   end

   gen_state_t        st;
   logic [CNT_W-1:0]  idx, last_idx;
   logic [127:0]      desc_q;
   logic [3:0]        fe_q, le_q;
   logic [LEN_W-1:0]  pcnt_q;
   logic              hint_q;
   logic [1:0]        htype_q;
   logic [7:0]        tag_q;
   logic              sop_q, last_q;
   logic [DATA_W-1:0] bdata;
   logic [NDW-1:0]    bkeep;
   logic [NB-1:0]     bpbe;

   logic [3:0]        fe_eff, le_eff, lane_be;
   logic [LEN_W-1:0]  pay_cnt, pay_idx;
   logic [SLOT_W-1:0] slot;
   logic              is_pay, dw_ok, last_dw, beat_end;
   logic [31:0]       dw;
   logic [31:0]       par;
   logic [31:0]       pbe32;

   rsg_be_rules #(.LEN_W(LEN_W)) u_rules (
      .kind(req_type), .len(req_len), .fe_in(req_first_be), .le_in(req_last_be),
      .fe_eff(fe_eff), .le_eff(le_eff), .pay_cnt(pay_cnt)
   );

   assign pay_idx = LEN_W'(idx - CNT_W'(DESC_DW));

   rsg_lane_be #(.LEN_W(LEN_W)) u_lane (
      .pay_idx(pay_idx), .pay_cnt(pcnt_q), .fe(fe_q), .le(le_q), .be(lane_be)
   );

   assign slot     = idx[SLOT_W-1:0];
   assign is_pay   = idx >= CNT_W'(DESC_DW);
   assign dw       = is_pay ? pl_data : desc_q[32*idx[1:0] +: 32];
   assign dw_ok    = !is_pay || pl_valid;
   assign last_dw  = idx == last_idx;
   assign beat_end = last_dw || (slot == SLOT_W'(NDW - 1));

   assign req_ready = st == S_IDLE;
   assign pl_ready  = (st == S_FILL) && is_pay;
   assign m_tvalid  = st == S_SEND;
   assign m_tlast   = last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= S_IDLE;
         idx      <= '0;
         last_idx <= '0;
         desc_q   <= '0;
         fe_q     <= '0;
         le_q     <= '0;
         pcnt_q   <= '0;
         hint_q   <= 1'b0;
         htype_q  <= '0;
         tag_q    <= '0;
         sop_q    <= 1'b0;
         last_q   <= 1'b0;
         bdata    <= '0;
         bkeep    <= '0;
         bpbe     <= '0;
      end else begin
         unique case (st)
            S_IDLE: if (req_valid) begin
               desc_q   <= req_desc;
               fe_q     <= fe_eff;
               le_q     <= le_eff;
               pcnt_q   <= pay_cnt;
               last_idx <= CNT_W'(pay_cnt) + CNT_W'(DESC_DW - 1);
               hint_q   <= req_hint_present;
               htype_q  <= req_hint_type;
               tag_q    <= req_steer_tag;
               idx      <= '0;
               sop_q    <= 1'b1;
               bdata    <= '0;
               bkeep    <= '0;
               bpbe     <= '0;
               st       <= S_FILL;
            end
            S_FILL: if (dw_ok) begin
               bdata[32*slot +: 32] <= dw;
               bkeep[slot]          <= 1'b1;
               bpbe[4*slot +: 4]    <= is_pay ? lane_be : 4'h0;
               idx                  <= idx + CNT_W'(1);
               if (beat_end) begin
                  last_q <= last_dw;
                  st     <= S_SEND;
               end
            end
            S_SEND: if (m_tready) begin
               if (last_q) begin
                  st <= S_IDLE;
               end else begin
                  st    <= S_FILL;
                  sop_q <= 1'b0;
                  bdata <= '0;
                  bkeep <= '0;
                  bpbe  <= '0;
               end
            end
            default: st <= S_IDLE;
         endcase
      end
   end

   rsg_parity #(.DATA_W(DATA_W)) u_par (.data(bdata), .par(par));

   if (DATA_W == MAX_DATA_W) begin : g_full
      assign m_tdata = bdata;
      assign m_tkeep = bkeep;
      assign pbe32   = bpbe;
   end else begin : g_narrow
      assign m_tdata = {{(MAX_DATA_W - DATA_W){1'b0}}, bdata};
      assign m_tkeep = {{(MAX_KEEP_W - NDW){1'b0}}, bkeep};
      assign pbe32   = {{(32 - NB){1'b0}}, bpbe};
   end

   always_comb begin
      m_tuser                    = '0;
      m_tuser[U_FBE +: 4]        = sop_q ? fe_q : 4'h0;
      m_tuser[U_LBE +: 4]        = sop_q ? le_q : 4'h0;
      m_tuser[U_PBE +: 32]       = pbe32;
      m_tuser[U_SOP]             = sop_q;
      m_tuser[U_DISC]            = 1'b0;
      m_tuser[U_HINT]            = sop_q & hint_q;
      m_tuser[U_HTYPE +: 2]      = sop_q ? htype_q : 2'b00;
      m_tuser[U_TAG +: 8]        = sop_q ? tag_q : 8'h00;
      m_tuser[U_PAR +: 32]       = par;
   end
endmodule

// File: rtl/rsg_checker.sv
module rsg_checker #(
   parameter int DATA_W = 256
) (
   input logic         clk,
   input logic         rst_n,
   input logic         m_tvalid,
   input logic         m_tready,
   input logic [255:0] m_tdata,
   input logic [7:0]   m_tkeep,
   input logic         m_tlast,
   input logic [84:0]  m_tuser
);
   localparam int NDW = DATA_W / 32;
   localparam int NB  = DATA_W / 8;
   localparam int DB  = (NB < 16) ? NB : 16;
   localparam logic [7:0]  FULL_KEEP = 8'((1 << NDW) - 1);
   localparam logic [31:0] DESC_MASK = 32'((64'd1 << DB) - 64'd1);

   logic        in_pkt;
   logic [31:0] keep_bytes;
   logic        keep_contig;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    in_pkt <= 1'b0;
      else if (m_tvalid && m_tready) in_pkt <= !m_tlast;
   end

   always_comb begin
      for (int i = 0; i < 32; i++) keep_bytes[i] = m_tkeep[i/4];
      keep_contig = m_tkeep[0] && ((m_tkeep & (m_tkeep + 8'd1)) == 8'd0);
   end

   p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      m_tvalid && !m_tready |=> m_tvalid && $stable(m_tdata) && $stable(m_tkeep)
                                && $stable(m_tlast) && $stable(m_tuser));

   p_keep_contig_r2: assert property (@(posedge clk) disable iff (!rst_n)
      m_tvalid |-> keep_contig);

   p_keep_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
      m_tvalid && !m_tlast |-> m_tkeep == FULL_KEEP);

   p_sop_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
      m_tvalid |-> m_tuser[40] == !in_pkt);

   p_desc_no_pbe_r7: assert property (@(posedge clk) disable iff (!rst_n)
      m_tvalid && m_tuser[40] |-> (m_tuser[39:8] & DESC_MASK) == 32'd0);

   p_pbe_in_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
      m_tvalid |-> (m_tuser[39:8] & ~keep_bytes) == 32'd0);
endmodule

bind request_sideband_gen rsg_checker #(.DATA_W(DATA_W)) u_rsg_chk (
   .clk(clk), .rst_n(rst_n), .m_tvalid(m_tvalid), .m_tready(m_tready),
   .m_tdata(m_tdata), .m_tkeep(m_tkeep), .m_tlast(m_tlast), .m_tuser(m_tuser)
);

// File: tb/tb_request_sideband_gen.sv
module tb_request_sideband_gen;
   localparam int TB_W  = 128;
   localparam int NDW   = TB_W / 32;
   localparam int NB    = TB_W / 8;
   localparam int LEN_W = 11;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic             rst_n;
   logic             req_valid, req_ready;
   logic [2:0]       req_type;
   logic [LEN_W-1:0] req_len;
   logic [3:0]       req_first_be, req_last_be;
   logic             req_hint_present;
   logic [1:0]       req_hint_type;
   logic [7:0]       req_steer_tag;
   logic [127:0]     req_desc;
   logic             pl_valid, pl_ready;
   logic [31:0]      pl_data;
   logic             m_tvalid, m_tready, m_tlast;
   logic [255:0]     m_tdata;
   logic [7:0]       m_tkeep;
   logic [84:0]      m_tuser;

   request_sideband_gen #(.DATA_W(TB_W), .LEN_W(LEN_W)) dut (.*);

   typedef struct packed {
      logic [255:0] d;
      logic [7:0]   k;
      logic         l;
      logic [84:0]  u;
   } beat_t;

   beat_t exp_q[$];
   string tag_q[$];
   int    n_chk = 0, n_fail = 0;
   int    rdy_pct = 100;

   task automatic chk(input bit ok, input string what, input logic [255:0] act, input logic [255:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s act=%h exp=%h", what, act, exp);
      end
   endtask

   task automatic send_req(input logic [2:0] kind, input int len, input logic [3:0] fe,
                           input logic [3:0] le, input string tag);
      logic [31:0]  pay[$];
      logic [127:0] desc;
      logic [3:0]   fe_e, le_e;
      logic         hp;
      logic [1:0]   ht;
      logic [7:0]   stg;
      bit           forced, has;
      int           p, t, nbt;
      desc   = {$urandom, $urandom, $urandom, $urandom};
      hp     = 1'($urandom);
      ht     = 2'($urandom);
      stg    = 8'($urandom);
      forced = (kind == 3'd4) || (kind == 3'd6);
      has    = (kind == 3'd1) || (kind == 3'd3) || forced;
      fe_e   = forced ? 4'hF : fe;
      le_e   = forced ? 4'hF : ((len <= 1) ? 4'h0 : le);
      p      = has ? len : 0;
      t      = 4 + p;
      nbt    = (t + NDW - 1) / NDW;
      for (int k = 0; k < p; k++) pay.push_back($urandom);
      for (int b = 0; b < nbt; b++) begin
         beat_t e;
         e = '0;
         for (int l = 0; l < NDW; l++) begin
            int dd;
            dd = b * NDW + l;
            if (dd < t) begin
               e.k[l] = 1'b1;
               e.d[32*l +: 32] = (dd < 4) ? desc[32*dd +: 32] : pay[dd-4];
               if (dd >= 4)
                  e.u[8 + 4*l +: 4] = (dd - 4 == 0) ? fe_e : ((dd - 4 == p - 1) ? le_e : 4'hF);
            end
         end
         e.l = (b == nbt - 1);
         if (b == 0) begin
            e.u[3:0]   = fe_e;
            e.u[7:4]   = le_e;
            e.u[40]    = 1'b1;
            e.u[42]    = hp;
            e.u[44:43] = ht;
            e.u[52:45] = stg;
         end
         for (int i = 0; i < NB; i++) e.u[53+i] = ~^e.d[8*i +: 8];
         exp_q.push_back(e);
         tag_q.push_back(tag);
      end
      @(negedge clk);
      req_type = kind; req_len = LEN_W'(len); req_first_be = fe; req_last_be = le;
      req_hint_present = hp; req_hint_type = ht; req_steer_tag = stg; req_desc = desc;
      req_valid = 1'b1;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      chk(req_ready == 1'b0, "R11 req_ready low while packet in flight", 256'(req_ready), 256'd0);
      foreach (pay[k]) begin
         repeat ($urandom_range(0, 2)) @(negedge clk);
         pl_data  = pay[k];
         pl_valid = 1'b1;
         while (!pl_ready) @(negedge clk);
         @(negedge clk);
         pl_valid = 1'b0;
      end
   endtask

   // monitor: stability during stalls, then scoreboard compare on each transfer
   initial begin
      beat_t prev, cur, e;
      bit    pv, ptk;
      string tg;
      pv = 1'b0; ptk = 1'b0; m_tready = 1'b0; prev = '0;
      forever begin
         @(negedge clk);
         cur = {m_tdata, m_tkeep, m_tlast, m_tuser};
         if (!rst_n) begin
            pv = 1'b0;
         end else begin
            if (pv && !ptk) begin
               chk(m_tvalid == 1'b1, "R4 valid dropped during stall", 256'(m_tvalid), 256'd1);
               chk(cur == prev, "R4 outputs changed during stall", cur.d, prev.d);
            end
            m_tready = ($urandom_range(0, 99) < rdy_pct);
            if (m_tvalid && m_tready) begin
               if (exp_q.size() == 0) begin
                  chk(1'b0, "R3 unexpected beat", m_tdata, 256'd0);
               end else begin
                  e  = exp_q.pop_front();
                  tg = tag_q.pop_front();
                  chk(m_tdata == e.d, {tg, " R1 tdata"}, m_tdata, e.d);
                  chk(m_tkeep == e.k, {tg, " R2 tkeep"}, 256'(m_tkeep), 256'(e.k));
                  chk(m_tlast == e.l, {tg, " R3 tlast"}, 256'(m_tlast), 256'(e.l));
                  chk(m_tuser[40] == e.u[40], {tg, " R3 start of packet"}, 256'(m_tuser[40]), 256'(e.u[40]));
                  chk(m_tuser[7:0] == e.u[7:0], {tg, " R5 first/last enables"}, 256'(m_tuser[7:0]), 256'(e.u[7:0]));
                  chk(m_tuser[39:8] == e.u[39:8], {tg, " R7 payload enables"}, 256'(m_tuser[39:8]), 256'(e.u[39:8]));
                  chk(m_tuser[52:42] == e.u[52:42], {tg, " R9 hint fields"}, 256'(m_tuser[52:42]), 256'(e.u[52:42]));
                  chk(m_tuser[84:53] == e.u[84:53] && m_tuser[41] == 1'b0, {tg, " R10 parity/discontinue"},
                      256'(m_tuser[84:41]), 256'(e.u[84:41]));
               end
            end
            pv   = m_tvalid;
            ptk  = m_tready;
            prev = cur;
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R4 run hung act=%0d exp=%0d", exp_q.size(), 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      rst_n = 1'b0; req_valid = 1'b0; pl_valid = 1'b0; pl_data = '0;
      req_type = '0; req_len = '0; req_first_be = '0; req_last_be = '0;
      req_hint_present = 1'b0; req_hint_type = '0; req_steer_tag = '0; req_desc = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(m_tvalid == 1'b0, "R11 reset tvalid", 256'(m_tvalid), 256'd0);
      chk(req_ready == 1'b1, "R11 reset req_ready", 256'(req_ready), 256'd1);

      rdy_pct = 100;
      send_req(3'd0, 1,  4'hF, 4'h0, "R6 one-dword read");
      send_req(3'd1, 1,  4'h0, 4'h0, "R8 zero-length write");
      send_req(3'd1, 1,  4'h5, 4'hF, "R6 one-dword write");
      send_req(3'd1, 2,  4'hC, 4'h3, "R7 two-dword write");
      send_req(3'd4, 2,  4'h1, 4'h2, "R5 atomic forced");
      send_req(3'd5, 1,  4'h3, 4'h0, "R1 message no data");
      send_req(3'd6, 3,  4'h0, 4'h0, "R5 message data forced");
      send_req(3'd3, 1,  4'h6, 4'h0, "R6 io write");
      send_req(3'd0, 9,  4'hF, 4'hF, "R1 multi-dword read");
      rdy_pct = 60;
      for (int n = 1; n <= 8; n++)
         send_req(3'd1, n, 4'hE, 4'h7, "R2 last lane sweep");
      send_req(3'd1, 12, 4'hF, 4'h1, "R2 exact multiple");
      for (int n = 0; n < 40; n++)
         send_req(3'($urandom_range(0, 6)), $urandom_range(1, 20), 4'($urandom), 4'($urandom), "R10 random");
      while (exp_q.size() != 0) @(negedge clk);
      repeat (5) @(negedge clk);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule